// File: doc/BRIEF.md
# Programmable Periodic Interrupt Divider

This block divides a 32.768 kHz time base, which arrives as a one-cycle enable on the system clock, down to a programmable periodic event. A 4-bit rate code selects the period as a power of two of base ticks. Every event falls on a boundary of a free-running 15-bit base-tick count, so changing the rate never shifts the phase of later events away from whole multiples of the new period.

Two outputs report each event. One is a one-cycle request that sets the periodic and interrupt-request flags held in a neighbouring status register. The other is a one-cycle pulse on the square-wave pin. Each output has its own enable bit. The rate code and both enables are held in the block and take effect when the control-write strobe is asserted. The values on the control inputs during the write cycle already govern that cycle's event decision.

Top module: `periodic_rate_divider`

## Requirements
- R1: After reset both outputs are low, the base-tick count is zero, and the held control is rate code 0 with both enables clear, so no event occurs until a control write.
- R2: The base-tick count advances by one, modulo 2^15, only in cycles where `base_tick` is high. An output pulse only follows a cycle in which `base_tick` was high.
- R3: For rate codes 3 to 15 the period is 2^(code-1) base ticks. An event fires on the base tick that brings the count to an exact multiple of the period.
- R4: Rate code 1 gives a period of 128 base ticks and rate code 2 gives 256, the same as codes 8 and 9.
- R5: Rate code 0 produces no events.
- R6: When both the periodic enable and the square-wave enable are clear, no events occur.
- R7: `pflag_set` is high for the one cycle that follows an event's base-tick cycle, and only when the periodic enable is set.
- R8: `sqw_pulse` is high for the one cycle that follows an event's base-tick cycle, and only when the square-wave enable is set. It does not depend on the periodic enable.
- R9: Control inputs are taken only in cycles where `ctrl_wr` is high, and they already apply in that cycle. Changes made without the strobe are ignored. A write adds no extra event and leaves the count untouched, so period alignment is kept.
- R10: Neither output is ever high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | One-cycle enable at the 32.768 kHz base rate |
| ctrl_wr | input | 1 | Control-write strobe; takes in the three control inputs |
| rate_code | input | 4 | Rate-select code (0 = off, 1/2 alias to 8/9, 3..15 = 2^(code-1) ticks) |
| per_en | input | 1 | Periodic flag enable |
| sqw_en | input | 1 | Square-wave pulse enable |
| pflag_set | output | 1 | One-cycle request to set the periodic and interrupt-request flags |
| sqw_pulse | output | 1 | One-cycle pulse on the square-wave pin |

## Verification
The event decision is made in the same cycle as the qualifying base tick, and both outputs are registered. Each pulse is therefore due exactly one clock cycle after the rising edge that consumes that base tick. A control write affects the decision in its own cycle and so the output one cycle later. The scoreboard works out the expected pair of outputs for every rising edge from the inputs the bench drove before that edge. It queues that pair, and the monitor compares it against the outputs at the following falling edge, so each result is sampled in the single cycle it belongs to. Interval checks on the continuous-tick phases also confirm that consecutive pulses are spaced by the full period.

// File: rtl/prd_pkg.sv
package prd_pkg;

  localparam int CODE_W = 4;

  typedef logic [CODE_W-1:0] rate_code_t;

  typedef struct packed {
    rate_code_t code;
    logic       per;
    logic       sqw;
  } ctrl_t;

  // Number of low count bits that must roll over for one event.
  // Codes 1 and 2 are lifted by seven before the exponent is taken.
  function automatic rate_code_t rate_shift(input rate_code_t c);
    rate_code_t s;
    if (c == '0)
      s = '0;
    else if (c < rate_code_t'(3))
      s = c + rate_code_t'(6);
    else
      s = c - rate_code_t'(1);
    return s;
  endfunction

  // Divider only runs with a nonzero code and at least one consumer.
  function automatic logic rate_active(input ctrl_t k);
    return (k.code != '0) && (k.per || k.sqw);
  endfunction

endpackage

// File: rtl/prd_ctrl_hold.sv
module prd_ctrl_hold
  import prd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr,
  input  ctrl_t new_cfg,
  output ctrl_t eff_cfg
);

  ctrl_t held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      held_q <= '0;
    else if (wr)
      held_q <= new_cfg;
  end

  // A write governs its own cycle.
  assign eff_cfg = wr ? new_cfg : held_q;

endmodule

// File: rtl/prd_base_counter.sv
module prd_base_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (adv)
      cnt <= cnt + CNT_W'(1);
  end

endmodule

// File: rtl/prd_tick_detect.sv
module prd_tick_detect
  import prd_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             base_tick,
  input  logic [CNT_W-1:0] cnt,
  input  ctrl_t            eff_cfg,
  output logic [CNT_W-1:0] low_mask,
  output logic             run_en,
  output logic             tick_evt
);

  rate_code_t shift;

  assign shift  = rate_shift(eff_cfg.code);
  assign run_en = rate_active(eff_cfg);

  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign low_mask[i] = (32'(shift) > i);
  end

  // Next count lands on a period boundary when the low bits are all ones.
  assign tick_evt = base_tick && run_en && ((cnt & low_mask) == low_mask);

endmodule

// File: rtl/prd_pulse_out.sv
module prd_pulse_out
  import prd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick_evt,
  input  ctrl_t eff_cfg,
  output logic  pflag_set,
  output logic  sqw_pulse
);

  localparam int NOUT = 2;

  logic [NOUT-1:0] en_vec;
  logic [NOUT-1:0] out_q;

  assign en_vec = {eff_cfg.sqw, eff_cfg.per};

  for (genvar j = 0; j < NOUT; j++) begin : g_out
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        out_q[j] <= 1'b0;
      else
        out_q[j] <= tick_evt && en_vec[j];
    end
  end

  assign pflag_set = out_q[0];
  assign sqw_pulse = out_q[1];

endmodule

// File: rtl/periodic_rate_divider.sv
module periodic_rate_divider
  import prd_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       base_tick,
  input  logic       ctrl_wr,
  input  logic [3:0] rate_code,
  input  logic       per_en,
  input  logic       sqw_en,
  output logic       pflag_set,
  output logic       sqw_pulse
);

  ctrl_t            new_cfg;
  ctrl_t            eff_cfg;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] low_mask;
  logic             run_en;
  logic             tick_evt;

  assign new_cfg = '{code: rate_code, per: per_en, sqw: sqw_en};

  prd_ctrl_hold u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (ctrl_wr),
    .new_cfg (new_cfg),
    .eff_cfg (eff_cfg)
  );

  prd_base_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (base_tick),
    .cnt   (cnt_q)
  );

  prd_tick_detect #(.CNT_W(CNT_W)) u_det (
    .base_tick (base_tick),
    .cnt       (cnt_q),
    .eff_cfg   (eff_cfg),
    .low_mask  (low_mask),
    .run_en    (run_en),
    .tick_evt  (tick_evt)
  );

  prd_pulse_out u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_evt  (tick_evt),
    .eff_cfg   (eff_cfg),
    .pflag_set (pflag_set),
    .sqw_pulse (sqw_pulse)
  );

endmodule

// File: rtl/prd_checker.sv
module prd_checker #(
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             base_tick,
  input logic             pflag_set,
  input logic             sqw_pulse,
  input logic             tick_evt,
  input logic             run_en,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] mask
);

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !base_tick |=> $stable(cnt));

  // R2
  pulse_needs_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pflag_set || sqw_pulse) |-> $past(base_tick));

  // R3
  tick_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_evt |=> ((cnt & $past(mask)) == '0));

  // R6
  idle_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !tick_evt);

  // R7
  pflag_from_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pflag_set |-> $past(tick_evt));

  // R8
  sqw_from_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sqw_pulse |-> $past(tick_evt));

  // R10
  pflag_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pflag_set |=> !pflag_set);

  // R10
  sqw_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sqw_pulse |=> !sqw_pulse);

endmodule

bind periodic_rate_divider prd_checker #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .base_tick (base_tick),
  .pflag_set (pflag_set),
  .sqw_pulse (sqw_pulse),
  .tick_evt  (tick_evt),
  .run_en    (run_en),
  .cnt       (cnt_q),
  .mask      (low_mask)
);

// File: tb/periodic_rate_divider_tb_top.sv
module periodic_rate_divider_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       base_tick = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic       per_en = 1'b0;
  logic       sqw_en = 1'b0;
  logic       pflag_set;
  logic       sqw_pulse;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  string tag   = "R1";
  int exp_gap  = 0;

  typedef struct { logic p; logic s; string t; } exp_t;
  exp_t sb_q[$];

  // bench model state
  int   m_cnt  = 0;
  int   m_code = 0;
  logic m_per  = 1'b0;
  logic m_sqw  = 1'b0;

  always #4 clk = ~clk;

  periodic_rate_divider dut_i (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .ctrl_wr(ctrl_wr),
    .rate_code(rate_code), .per_en(per_en), .sqw_en(sqw_en),
    .pflag_set(pflag_set), .sqw_pulse(sqw_pulse)
  );

  function automatic int period_of(input int code);
    int c = code;
    if (c == 1 || c == 2) c = c + 7;
    return 1 << (c - 1);
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Model: predicts the outputs due one cycle after each rising edge.
  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      int   code;
      logic pe, se, ev;
      exp_t e;
      code = ctrl_wr ? int'(rate_code) : m_code;
      pe   = ctrl_wr ? per_en : m_per;
      se   = ctrl_wr ? sqw_en : m_sqw;
      ev   = 1'b0;
      if (base_tick) begin
        m_cnt = (m_cnt + 1) % 32768;
        if (code != 0 && (pe || se) && (m_cnt % period_of(code)) == 0)
          ev = 1'b1;
      end
      if (ctrl_wr) begin
        m_code = int'(rate_code);
        m_per  = per_en;
        m_sqw  = sqw_en;
      end
      e.p = ev && pe;
      e.s = ev && se;
      e.t = tag;
      sb_q.push_back(e);
    end
  end

  // Monitor: compares at the falling edge after each rising edge.
  int   last_p = -1;
  logic prev_p = 1'b0;
  logic prev_s = 1'b0;
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(pflag_set === e.p, e.t, "pflag_set", int'(pflag_set), int'(e.p));
      check(sqw_pulse === e.s, e.t, "sqw_pulse", int'(sqw_pulse), int'(e.s));
      if (prev_p && pflag_set)
        check(1'b0, "R10", "pflag_set back-to-back", 1, 0);
      if (prev_s && sqw_pulse)
        check(1'b0, "R10", "sqw_pulse back-to-back", 1, 0);
      if (pflag_set && exp_gap > 0) begin
        if (last_p >= 0)
          check((cyc - last_p) == exp_gap, e.t, "pulse spacing",
                cyc - last_p, exp_gap);
        last_p = cyc;
      end
    end
    prev_p = pflag_set;
    prev_s = sqw_pulse;
  end

  task automatic write_ctrl(input int code, input logic pe, input logic se);
    @(negedge clk);
    ctrl_wr   = 1'b1;
    rate_code = 4'(code);
    per_en    = pe;
    sqw_en    = se;
    @(negedge clk);
    ctrl_wr   = 1'b0;
  endtask

  // Runs n cycles with a base tick every gap cycles.
  task automatic run_ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      base_tick = ((i % gap) == 0);
    end
    @(negedge clk);
    base_tick = 1'b0;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", cyc, 0);
    report();
  end

  initial begin
    base_tick = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check(pflag_set === 1'b0, "R1", "pflag_set in reset", int'(pflag_set), 0);
    check(sqw_pulse === 1'b0, "R1", "sqw_pulse in reset", int'(sqw_pulse), 0);
    base_tick = 1'b0;
    rst_n = 1'b1;

    // R1 / R9: inputs set without a write are ignored, held control is off
    tag = "R1";
    rate_code = 4'd3; per_en = 1'b1; sqw_en = 1'b1;
    run_ticks(60, 1);

    // R3 / R7: code 3, periodic only, continuous base ticks, spacing 4
    tag = "R3"; exp_gap = 4;
    write_ctrl(3, 1'b1, 1'b0);
    run_ticks(80, 1);
    exp_gap = 0; last_p = -1;

    // R8 / R2: code 6, square wave only, base tick every third cycle
    tag = "R8";
    write_ctrl(6, 1'b0, 1'b1);
    run_ticks(500, 3);

    // R4: code 1 behaves as period 128, both outputs
    tag = "R4"; exp_gap = 128;
    write_ctrl(1, 1'b1, 1'b1);
    run_ticks(700, 1);
    last_p = -1;

    // R4: code 2 behaves as period 256
    exp_gap = 256;
    write_ctrl(2, 1'b1, 1'b0);
    run_ticks(900, 1);
    exp_gap = 0; last_p = -1;

    // R5: code 0 gives no events
    tag = "R5";
    write_ctrl(0, 1'b1, 1'b1);
    run_ticks(300, 1);

    // R6: both enables clear
    tag = "R6";
    write_ctrl(4, 1'b0, 1'b0);
    run_ticks(300, 1);

    // R9: changes without the strobe are ignored
    tag = "R9";
    rate_code = 4'd3; per_en = 1'b1; sqw_en = 1'b1;
    run_ticks(200, 1);

    // R9: writes with base ticks running keep alignment, no extra event
    write_ctrl(5, 1'b1, 1'b0);
    run_ticks(37, 1);
    @(negedge clk);
    base_tick = 1'b1; ctrl_wr = 1'b1; rate_code = 4'd3; per_en = 1'b1; sqw_en = 1'b1;
    @(negedge clk);
    ctrl_wr = 1'b0;
    run_ticks(120, 2);

    // R3 / R7: slowest rate, code 15, period 16384
    tag = "R7"; exp_gap = 16384;
    write_ctrl(15, 1'b1, 1'b0);
    run_ticks(34000, 1);
    exp_gap = 0;

    repeat (4) @(negedge clk);
    report();
  end

endmodule